// File: doc/BRIEF.md
# Indirect L1 Data-Array Test Access Engine

This block lets software reach the on-chip L1 data-array memory through a small set of registers instead of through the normal load/store path. Software first places two 32-bit test-data words, then writes a command word. A nonzero command that passes its checks starts one 64-bit transaction on a request/acknowledge memory port. A write-type command stores the two data words. A read-type command loads the returned 64 bits back into the two data words.

The memory address does not come from a linear field. The engine scatters individual command bits into the way, bank, subbank and instruction/data positions of the address, lets a group of index bits pass through unchanged, and ORs the result with a fixed SRAM base. Commands that set reserved bits, or that aim at the tag array rather than the data array, raise a one-cycle error pulse and do not touch memory. While a transaction is in flight the engine reports busy and drops every register write.

Top module: `l1_test_access`

## Requirements
- R1: After reset the command and both data words read zero, busy and the memory request are low, and both error pulses are low.
- R2: Writing zero to the command register stores zero and starts no memory request and no error.
- R3: The access address takes command bit 26 into address bit 11, command bit 24 into address bit 21, command bit 23 into address bit 15, command bits 17:16 into address bits 13:12, and passes command bits 14 and 10:3 straight through to the same address bits.
- R4: The scattered address is ORed with the SRAM base parameter (default 0xFF800000) to form the memory address.
- R5: A nonzero command with any bit under mask 0xFA7CB801 set pulses the reserved-bit error for one cycle and starts no request.
- R6: A nonzero command with bit 2 (data-array select) clear pulses the tag-array error for one cycle and starts no request.
- R7: Command bit 1 set makes the transaction a store (write enable high) whose 64-bit write data is data word 1 in the upper half and data word 0 in the lower half.
- R8: With command bit 1 clear the transaction is a load; on acknowledge data word 0 takes read data bits 31:0 and data word 1 takes bits 63:32.
- R9: Busy and the memory request rise on the clock edge that accepts a valid command and fall on the edge that sees the acknowledge; address and write enable stay stable in between.
- R10: While busy, writes to the command and data registers are dropped and raise no error.
- R11: While idle, writes to data word 0 (select 1) and data word 1 (select 2) update those words; select 0 addresses the command register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 data word 0, 2 data word 1 |
| reg_wdata | input | 32 | Register write value |
| cmd_q | output | 32 | Stored command word |
| data0_q | output | 32 | Test-data word 0 (low half) |
| data1_q | output | 32 | Test-data word 1 (high half) |
| busy | output | 1 | Transaction in flight |
| err_rsvd | output | 1 | One-cycle pulse: reserved command bit set |
| err_tag | output | 1 | One-cycle pulse: tag array selected |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Memory store when high, load when low |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 64 | Store data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 64 | Load data, valid with acknowledge |

## Verification
The hardest situation to reach is a register write landing in the window between request and acknowledge, since it only exists while the memory port stalls. The bench's memory model holds off its acknowledge for a varying number of cycles on every transaction and, inside that window, fires an all-ones command and a data write, then confirms the stored words, address and error pulses are unchanged. Every single command bit is swept on its own with the array bit set, followed by pseudo-random legal commands, so each scatter path and each reserved position is covered with an address computed by shifts and masks in the bench.

// File: rtl/l1ta_pkg.sv
package l1ta_pkg;

  localparam int CMD_W = 32;

  // register select codes
  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_DAT0 = 2'd1;
  localparam logic [1:0] SEL_DAT1 = 2'd2;

  // command field positions (behaviour depends on these)
  localparam int BIT_STORE   = 1;
  localparam int BIT_ARRAY   = 2;
  localparam int BIT_WAY     = 26;
  localparam int BIT_SPACE   = 24;
  localparam int BIT_BANK    = 23;
  localparam int BIT_SUB_LO  = 16;

  // destination address positions
  localparam int ADR_WAY     = 11;
  localparam int ADR_SPACE   = 21;
  localparam int ADR_BANK    = 15;
  localparam int ADR_SUB_LO  = 12;

  localparam logic [CMD_W-1:0] RSVD_MASK = 32'hFA7C_B801;
  localparam logic [CMD_W-1:0] PASS_MASK = 32'h0000_47F8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } xfer_state_e;

endpackage

// File: rtl/l1ta_addr_map.sv
module l1ta_addr_map
  import l1ta_pkg::*;
#(
  parameter int              AW   = 32,
  parameter logic [AW-1:0]   BASE = 32'hFF80_0000
) (
  input  logic [CMD_W-1:0] cmd,
  output logic [AW-1:0]    addr
);

  localparam int SW = (AW > CMD_W) ? AW : CMD_W;

  logic [SW-1:0] scatter;

  always_comb begin
    scatter                          = '0;
    scatter[CMD_W-1:0]               = cmd & PASS_MASK;
    scatter[ADR_WAY]                 = cmd[BIT_WAY];
    scatter[ADR_SPACE]               = cmd[BIT_SPACE];
    scatter[ADR_BANK]                = cmd[BIT_BANK];
    scatter[ADR_SUB_LO+1:ADR_SUB_LO] = cmd[BIT_SUB_LO+1:BIT_SUB_LO];
    addr                             = BASE | scatter[AW-1:0];
  end

endmodule

// File: rtl/l1ta_cmd_check.sv
module l1ta_cmd_check
  import l1ta_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output logic             rsvd_hit,
  output logic             tag_sel,
  output logic             launch,
  output logic             store
);

  logic nonzero;

  always_comb begin
    nonzero  = |cmd;
    rsvd_hit = nonzero && |(cmd & RSVD_MASK);
    tag_sel  = nonzero && !cmd[BIT_ARRAY];
    launch   = nonzero && !rsvd_hit && !tag_sel;
    store    = cmd[BIT_STORE];
  end

endmodule

// File: rtl/l1ta_xfer_fsm.sv
module l1ta_xfer_fsm
  import l1ta_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  output logic busy,
  output logic done
);

  xfer_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_XFER;
      ST_XFER: if (ack)   state_d = ST_IDLE;
      default:            state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q == ST_XFER);
  assign done = busy && ack;

endmodule

// File: rtl/l1_test_access.sv
module l1_test_access
  import l1ta_pkg::*;
#(
  parameter int            DW   = 32,
  parameter int            AW   = 32,
  parameter logic [AW-1:0] BASE = 32'hFF80_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [1:0]      reg_sel,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   cmd_q,
  output logic [DW-1:0]   data0_q,
  output logic [DW-1:0]   data1_q,
  output logic            busy,
  output logic            err_rsvd,
  output logic            err_tag,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [2*DW-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [2*DW-1:0] mem_rdata
);

  localparam int MW = 2 * DW;

  logic          acc_ok;
  logic          cmd_wr, dat0_wr, dat1_wr;
  logic          chk_rsvd, chk_tag, chk_launch, chk_store;
  logic          start, done;
  logic [AW-1:0] addr_d;
  logic          load_en;

  // clock-enable decode; all writes dropped while busy
  assign acc_ok  = reg_we && !busy;
  assign cmd_wr  = acc_ok && (reg_sel == SEL_CMD);
  assign dat0_wr = acc_ok && (reg_sel == SEL_DAT0);
  assign dat1_wr = acc_ok && (reg_sel == SEL_DAT1);

  l1ta_cmd_check u_check (
    .cmd      (reg_wdata[CMD_W-1:0]),
    .rsvd_hit (chk_rsvd),
    .tag_sel  (chk_tag),
    .launch   (chk_launch),
    .store    (chk_store)
  );

  l1ta_addr_map #(.AW(AW), .BASE(BASE)) u_map (
    .cmd  (reg_wdata[CMD_W-1:0]),
    .addr (addr_d)
  );

  assign start = cmd_wr && chk_launch;

  l1ta_xfer_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .ack   (mem_ack),
    .busy  (busy),
    .done  (done)
  );

  assign load_en = done && !mem_we;

  // command register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_wr) cmd_q <= reg_wdata;
  end

  // data word 0: software write or low half of a load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data0_q <= '0;
    else if (load_en) data0_q <= mem_rdata[DW-1:0];
    else if (dat0_wr) data0_q <= reg_wdata;
  end

  // data word 1: software write or high half of a load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data1_q <= '0;
    else if (load_en) data1_q <= mem_rdata[MW-1:DW];
    else if (dat1_wr) data1_q <= reg_wdata;
  end

  // transaction attributes captured at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_we   <= 1'b0;
    end else if (start) begin
      mem_addr <= addr_d;
      mem_we   <= chk_store;
    end
  end

  // one-cycle error pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_rsvd <= 1'b0;
      err_tag  <= 1'b0;
    end else begin
      err_rsvd <= cmd_wr && chk_rsvd;
      err_tag  <= cmd_wr && chk_tag;
    end
  end

  assign mem_req   = busy;
  assign mem_wdata = {data1_q, data0_q};

endmodule

// File: rtl/l1ta_checker.sv
module l1ta_checker
  import l1ta_pkg::*;
#(
  parameter int            DW   = 32,
  parameter int            AW   = 32,
  parameter logic [AW-1:0] BASE = 32'hFF80_0000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [1:0]    reg_sel,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] cmd_q,
  input logic [DW-1:0] data0_q,
  input logic          busy,
  input logic          err_rsvd,
  input logic          err_tag,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack
);

  AST_START_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(reg_we && reg_sel == SEL_CMD && reg_wdata != '0)); // R2

  AST_ADDR_IN_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr & BASE) == BASE)); // R4

  AST_ERR_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rsvd || err_tag) |-> !$rose(mem_req)); // R5

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9

  AST_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req); // R9

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ack) |=> ($stable(cmd_q) && $stable(data0_q) && !err_rsvd && !err_tag)); // R10

endmodule

bind l1_test_access l1ta_checker #(.DW(DW), .AW(AW), .BASE(BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .cmd_q     (cmd_q),
  .data0_q   (data0_q),
  .busy      (busy),
  .err_rsvd  (err_rsvd),
  .err_tag   (err_tag),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack)
);

// File: tb/l1_test_access_test.sv
module l1_test_access_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          WD_CYCLES  = 100000;
  localparam logic [31:0] BASE_T     = 32'hFF80_0000;
  localparam logic [31:0] RSVD_T     = 32'hFA7C_B801;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] cmd_q, data0_q, data1_q;
  logic        busy, err_rsvd, err_tag;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1357_9BDF;

  l1_test_access uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_q(cmd_q), .data0_q(data0_q),
    .data1_q(data1_q), .busy(busy), .err_rsvd(err_rsvd), .err_tag(err_tag),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] c);
    return BASE_T | ((c >> 15) & 32'h0000_0800) | ((c >> 3) & 32'h0020_0000)
         | ((c >> 8) & 32'h0000_8000) | ((c >> 4) & 32'h0000_3000)
         | (c & 32'h0000_47F8);
  endfunction

  function automatic logic [63:0] mem_model(input logic [31:0] a);
    return {a ^ 32'hA5A5_0000, a + 32'h0000_0011};
  endfunction

  task automatic write_reg(input logic [1:0] sel, input logic [31:0] val);
    reg_we    = 1'b1;
    reg_sel   = sel;
    reg_wdata = val;
    @(posedge clk);
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  // runs one accepted command through to acknowledge and checks it
  task automatic run_cmd(input logic [31:0] c, input int delay);
    logic [31:0] d0, d1, a;
    d0 = c ^ 32'h0F0F_1234;
    d1 = ~c;
    write_reg(2'd1, d0);
    write_reg(2'd2, d1);
    write_reg(2'd0, c);
    a = exp_addr(c);
    check("R9 busy after accept", {63'd0, busy}, 64'd1);
    check("R3/R4 address", {32'd0, mem_addr}, {32'd0, a});
    check("R7 write enable", {63'd0, mem_we}, {63'd0, c[1]});
    if (c[1]) check("R7 store data", mem_wdata, {d1, d0});
    // R10: writes during the stall are dropped
    write_reg(2'd0, 32'hFFFF_FFFF);
    write_reg(2'd1, 32'hDEAD_BEEF);
    check("R10 cmd kept", {32'd0, cmd_q}, {32'd0, c});
    check("R10 data kept", {32'd0, data0_q}, {32'd0, d0});
    check("R10 no error", {62'd0, err_rsvd, err_tag}, 64'd0);
    for (int k = 0; k < delay; k++) @(negedge clk);
    check("R9 held", {31'd0, mem_req, a}, {31'd0, 1'b1, a});
    mem_ack   = 1'b1;
    mem_rdata = mem_model(a);
    @(posedge clk);
    @(negedge clk);
    mem_ack   = 1'b0;
    check("R9 released", {62'd0, busy, mem_req}, 64'd0);
    if (!c[1]) check("R8 load data", {data1_q, data0_q}, mem_model(a));
    else       check("R7 data unchanged", {data1_q, data0_q}, {d1, d0});
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    reg_we    = 1'b0;
    reg_sel   = 2'd0;
    reg_wdata = '0;
    mem_ack   = 1'b0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cmd", {32'd0, cmd_q}, 64'd0);
    check("R1 data", {data1_q, data0_q}, 64'd0);
    check("R1 flags", {60'd0, busy, mem_req, err_rsvd, err_tag}, 64'd0);

    // R11 idle data writes
    write_reg(2'd1, 32'h1122_3344);
    write_reg(2'd2, 32'h5566_7788);
    check("R11 data words", {data1_q, data0_q}, 64'h5566_7788_1122_3344);

    // single-bit sweep with array select held
    for (int i = 0; i < 32; i++) begin
      logic [31:0] c;
      c = (32'd1 << i) | 32'd4;
      if ((c & RSVD_T) != 0) begin
        write_reg(2'd0, c);
        check("R5 reserved pulse", {62'd0, err_rsvd, err_tag}, 64'd2);
        check("R5 no request", {63'd0, mem_req}, 64'd0);
        check("R5 cmd stored", {32'd0, cmd_q}, {32'd0, c});
        @(negedge clk);
        check("R5 pulse ends", {63'd0, err_rsvd}, 64'd0);
      end else begin
        run_cmd(c, i % 4);
      end
    end

    // R2 zero command after a completed access
    write_reg(2'd0, 32'd0);
    check("R2 stored zero", {32'd0, cmd_q}, 64'd0);
    check("R2 no access", {60'd0, busy, mem_req, err_rsvd, err_tag}, 64'd0);

    // R6 tag array selected
    write_reg(2'd0, 32'h0100_0000);
    check("R6 tag pulse", {62'd0, err_rsvd, err_tag}, 64'd1);
    check("R6 no request", {63'd0, mem_req}, 64'd0);
    write_reg(2'd0, 32'h8000_0002);
    check("R5 R6 both", {62'd0, err_rsvd, err_tag}, 64'd3);
    check("R6 no request both", {63'd0, mem_req}, 64'd0);

    // pseudo-random legal commands
    for (int n = 0; n < 48; n++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      run_cmd((seed & ~RSVD_T) | 32'd4, n % 3);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule